// File: doc/BRIEF.md
# Synchronous Dual-Ratio Clock Divider

This block takes one fast input clock and derives two slower clocks from it. Output A runs at one half or one quarter of the input rate. Output B runs at one quarter or one sixth of the input rate. Each output has its own ratio select. Both outputs are decoded from a single shared phase counter and registered on the rising input edge. As a result, every edge the two outputs have in common falls on the same input edge.

An active-low enable starts and stops division. It is captured on the falling input edge, so its value is already settled before the next rising edge. The rising edge then either advances the phase by a whole cycle or holds it, and no stage ever sees a shortened pulse. While the block is disabled, the phase and both outputs freeze, and division resumes from that same phase.

A synchronous master reset clears the phase and drives both outputs low. Several instances released from one common reset and fed the same controls therefore produce identical waveforms. A ratio select that changes is adopted only when the shared phase wraps back to zero, so no output period is cut short.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: With `sel_a` low, `clk_a` toggles on every enabled rising edge (divide by 2). With `sel_a` high, `clk_a` is high for 2 and low for 2 enabled input cycles (divide by 4).
- R2: With `sel_b` low, `clk_b` is high for 2 and low for 2 enabled input cycles (divide by 4). With `sel_b` high, it is high for 3 and then low for 3 (divide by 6, 50% duty).
- R3: Both outputs come from one 12-step phase. Phase 0 is the state after reset. The first enabled edge after reset moves to phase 1. At phase p, an output of ratio r is high exactly when (p mod r) is at least r/2. So both outputs are low at phase 0, and when both ratios are 4 the outputs are identical.
- R4: `en_n` is sampled on the falling input edge. The value captured there decides whether the following rising edge advances the phase: 0 means advance, 1 means hold. While the phase holds, both outputs keep their values.
- R5: After a disabled stretch, division resumes from the exact phase at which it stopped.
- R6: `mrst` high at a rising edge clears the phase to 0 and drives both outputs low on that edge, whatever the other inputs are.
- R7: A select value is taken in only on the edge where the phase wraps to 0, or during reset. A change at any other time leaves the running ratio unchanged until the wrap.
- R8: Two instances that share a common reset and identical inputs afterwards drive identical outputs, whatever phase each had before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| mrst | input | 1 | Synchronous active-high master reset |
| en_n | input | 1 | Active-low enable, captured on the falling edge |
| sel_a | input | 1 | Output A ratio: 0 selects divide by 2, 1 selects divide by 4 |
| sel_b | input | 1 | Output B ratio: 0 selects divide by 4, 1 selects divide by 6 |
| clk_a | output | 1 | Divided clock A |
| clk_b | output | 1 | Divided clock B |

## Verification
A wrong phase count appears at the ports within one input cycle as a misplaced edge on `clk_a` in its divide-by-2 mode. In the slower modes it shows up within three cycles as a high or low run of the wrong length. A select adopted away from the wrap distorts the very next output period. An enable that fails to freeze the phase moves an output edge on the first disabled cycle. A reset that leaves any state behind shows up as a misalignment between two instances soon after their common release.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef struct packed {
        logic a;
        logic b;
    } tap_pair_t;

    function automatic int unsigned gcd(input int unsigned x, input int unsigned y);
        int unsigned u;
        int unsigned v;
        int unsigned t;
        u = x;
        v = y;
        for (int i = 0; i < 64; i++) begin
            if (v != 0) begin
                t = u % v;
                u = v;
                v = t;
            end
        end
        return u;
    endfunction

    function automatic int unsigned lcm2(input int unsigned x, input int unsigned y);
        return (x / gcd(x, y)) * y;
    endfunction

    function automatic int unsigned lcm4(input int unsigned p, input int unsigned q,
                                         input int unsigned r, input int unsigned s);
        return lcm2(lcm2(p, q), lcm2(r, s));
    endfunction

    // Output level for a given phase and ratio: upper half of each period is high.
    function automatic logic phase_high(input int unsigned ph, input int unsigned ratio);
        return (ph % ratio) >= (ratio / 2);
    endfunction

endpackage

// File: rtl/clkdiv_en_capture.sv
module clkdiv_en_capture (
    input  logic clk,
    input  logic mrst,
    input  logic en_n,
    output logic en_ok
);
    // Sampled on the falling edge so the rising-edge logic sees a settled level.
    always_ff @(negedge clk) begin
        if (mrst) en_ok <= 1'b0;
        else      en_ok <= ~en_n;
    end
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
    import clkdiv_pkg::*;
#(
    parameter int unsigned MOD = 12,
    parameter int unsigned PW  = 4
) (
    input  logic            clk,
    input  logic            mrst,
    input  logic            step,
    input  tap_pair_t       sel_in,
    output logic [PW-1:0]   phase_q,
    output logic [PW-1:0]   phase_d,
    output tap_pair_t       sel_q,
    output tap_pair_t       sel_d
);
    localparam logic [PW-1:0] LAST = PW'(MOD - 1);

    always_comb begin
        phase_d = (phase_q == LAST) ? '0 : phase_q + PW'(1);
        sel_d   = (phase_d == '0) ? sel_in : sel_q;
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            phase_q <= '0;
            sel_q   <= sel_in;
        end else if (step) begin
            phase_q <= phase_d;
            sel_q   <= sel_d;
        end
    end
endmodule

// File: rtl/clkdiv_tap.sv
module clkdiv_tap
    import clkdiv_pkg::*;
#(
    parameter int unsigned LO = 2,
    parameter int unsigned HI = 4,
    parameter int unsigned PW = 4
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          step,
    input  logic [PW-1:0] phase_d,
    input  logic          sel,
    output logic          q
);
    logic lvl;

    always_comb lvl = phase_high(32'(phase_d), sel ? HI : LO);

    always_ff @(posedge clk) begin
        if (mrst)      q <= 1'b0;
        else if (step) q <= lvl;
    end
endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv
    import clkdiv_pkg::*;
#(
    parameter int unsigned A_LO = 2,
    parameter int unsigned A_HI = 4,
    parameter int unsigned B_LO = 4,
    parameter int unsigned B_HI = 6
) (
    input  logic clk_in,
    input  logic mrst,
    input  logic en_n,
    input  logic sel_a,
    input  logic sel_b,
    output logic clk_a,
    output logic clk_b
);
    localparam int unsigned MOD = lcm4(A_LO, A_HI, B_LO, B_HI);
    localparam int unsigned PW  = (MOD > 2) ? $clog2(MOD) : 1;

    logic            en_ok;
    logic [PW-1:0]   phase;
    logic [PW-1:0]   phase_nxt;
    tap_pair_t       sel_raw;
    tap_pair_t       sel_act;
    tap_pair_t       sel_nxt;
    logic            ph_zero;
    logic            ph_last;

    always_comb begin
        sel_raw.a = sel_a;
        sel_raw.b = sel_b;
        ph_zero   = (phase == '0);
        ph_last   = (phase == PW'(MOD - 1));
    end

    clkdiv_en_capture u_en (
        .clk   (clk_in),
        .mrst  (mrst),
        .en_n  (en_n),
        .en_ok (en_ok)
    );

    clkdiv_phase #(.MOD(MOD), .PW(PW)) u_phase (
        .clk     (clk_in),
        .mrst    (mrst),
        .step    (en_ok),
        .sel_in  (sel_raw),
        .phase_q (phase),
        .phase_d (phase_nxt),
        .sel_q   (sel_act),
        .sel_d   (sel_nxt)
    );

    clkdiv_tap #(.LO(A_LO), .HI(A_HI), .PW(PW)) u_tap_a (
        .clk     (clk_in),
        .mrst    (mrst),
        .step    (en_ok),
        .phase_d (phase_nxt),
        .sel     (sel_nxt.a),
        .q       (clk_a)
    );

    clkdiv_tap #(.LO(B_LO), .HI(B_HI), .PW(PW)) u_tap_b (
        .clk     (clk_in),
        .mrst    (mrst),
        .step    (en_ok),
        .phase_d (phase_nxt),
        .sel     (sel_nxt.b),
        .q       (clk_b)
    );
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk (
    input logic clk,
    input logic mrst,
    input logic en_ok,
    input logic ph_zero,
    input logic ph_last,
    input logic sel_a_q,
    input logic sel_b_q,
    input logic clk_a,
    input logic clk_b
);
    // R6
    reset_clears_chk: assert property (@(posedge clk)
        mrst |=> (!clk_a && !clk_b && ph_zero));

    // R4
    disabled_hold_chk: assert property (@(posedge clk) disable iff (mrst)
        !en_ok |=> ($stable(clk_a) && $stable(clk_b) && $stable(ph_zero)));

    // R1
    div2_toggle_chk: assert property (@(posedge clk) disable iff (mrst)
        (en_ok && !sel_a_q && !ph_last) |=> (clk_a != $past(clk_a)));

    // R3
    div4_pair_match_chk: assert property (@(posedge clk) disable iff (mrst)
        (sel_a_q && !sel_b_q) |-> (clk_a == clk_b));

    // R7
    sel_wrap_only_chk: assert property (@(posedge clk) disable iff (mrst)
        !ph_zero |-> ($stable(sel_a_q) && $stable(sel_b_q)));
endmodule

bind dual_ratio_clkdiv clkdiv_chk u_chk (
    .clk     (clk_in),
    .mrst    (mrst),
    .en_ok   (en_ok),
    .ph_zero (ph_zero),
    .ph_last (ph_last),
    .sel_a_q (sel_act.a),
    .sel_b_q (sel_act.b),
    .clk_a   (clk_a),
    .clk_b   (clk_b)
);

// File: tb/tb_dual_ratio_clkdiv.sv
module tb_dual_ratio_clkdiv;
    logic clk = 1'b0;
    logic mrst = 1'b1;
    logic en_n = 1'b0;
    logic en_n2 = 1'b0;
    logic sel_a = 1'b0;
    logic sel_b = 1'b0;
    logic clk_a, clk_b, clk_a2, clk_b2;

    int total = 0;
    int fails = 0;
    bit done = 0;
    bit tie2 = 1;

    // reference state from the requirements
    int m_ph = 0;
    bit m_sa = 0, m_sb = 0, m_a = 0, m_b = 0;

    always #5 clk = ~clk;

    dual_ratio_clkdiv dut (
        .clk_in(clk), .mrst(mrst), .en_n(en_n), .sel_a(sel_a), .sel_b(sel_b),
        .clk_a(clk_a), .clk_b(clk_b)
    );

    dual_ratio_clkdiv dut2 (
        .clk_in(clk), .mrst(mrst), .en_n(en_n2), .sel_a(sel_a), .sel_b(sel_b),
        .clk_a(clk_a2), .clk_b(clk_b2)
    );

    function automatic bit lvl(int ph, int r);
        return (ph % r) >= (r / 2);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit r, input bit e_n, input bit sa, input bit sb);
        if (r) begin
            m_ph = 0; m_a = 0; m_b = 0; m_sa = sa; m_sb = sb;
        end else if (!e_n) begin
            m_ph = (m_ph == 11) ? 0 : m_ph + 1;
            if (m_ph == 0) begin m_sa = sa; m_sb = sb; end
            m_a = lvl(m_ph, m_sa ? 4 : 2);
            m_b = lvl(m_ph, m_sb ? 6 : 4);
        end
    endtask

    task automatic tick(input bit r, input bit e_n, input bit sa, input bit sb, input string tag);
        mrst = r; en_n = e_n; sel_a = sa; sel_b = sb;
        if (tie2) en_n2 = e_n;
        @(posedge clk);
        model_step(r, e_n, sa, sb);
        #2;
        check(clk_a, m_a, tag, "clk_a");
        check(clk_b, m_b, tag, "clk_b");
        if (tie2) begin
            check(clk_a2, clk_a, "R8", "clk_a2 vs clk_a");
            check(clk_b2, clk_b, "R8", "clk_b2 vs clk_b");
        end
    endtask

    // R1 R2: duty and period measured on raw samples
    task automatic run_combo(input bit sa, input bit sb);
        logic ha [24];
        logic hb [24];
        int ra, rb, na, nb;
        bit pa, pb;
        ra = sa ? 4 : 2;
        rb = sb ? 6 : 4;
        tick(1, 0, sa, sb, "R6");
        for (int i = 0; i < 24; i++) begin
            tick(0, 0, sa, sb, "R1/R2");
            ha[i] = clk_a;
            hb[i] = clk_b;
        end
        na = 0; nb = 0; pa = 1; pb = 1;
        for (int i = 0; i < 24; i++) begin
            if (ha[i]) na++;
            if (hb[i]) nb++;
        end
        for (int i = 0; i + ra < 24; i++)
            if (ha[i] !== ha[i + ra] || ha[i] === ha[i + ra / 2]) pa = 0;
        for (int i = 0; i + rb < 24; i++)
            if (hb[i] !== hb[i + rb] || hb[i] === hb[i + rb / 2]) pb = 0;
        check(1'(na == 12), 1'b1, "R1", "clk_a duty");
        check(pa, 1'b1, "R1", "clk_a period");
        check(1'(nb == 12), 1'b1, "R2", "clk_b duty");
        check(pb, 1'b1, "R2", "clk_b period");
    endtask

    initial begin
        void'($urandom(32'd4242));
        #2;
        // R6: reset state
        tick(1, 0, 0, 0, "R6");
        tick(1, 1, 1, 1, "R6");
        check(clk_a, 1'b0, "R6", "clk_a in reset");
        check(clk_b, 1'b0, "R6", "clk_b in reset");

        run_combo(0, 0);
        run_combo(0, 1);
        run_combo(1, 0);
        run_combo(1, 1);

        // R3: both divide by 4 are identical
        tick(1, 0, 1, 0, "R6");
        for (int i = 0; i < 12; i++) begin
            tick(0, 0, 1, 0, "R3");
            check(clk_a, clk_b, "R3", "div4 pair");
        end

        // R4 R5: freeze mid-period, then resume
        tick(1, 0, 0, 1, "R6");
        for (int i = 0; i < 4; i++) tick(0, 0, 0, 1, "R5");
        for (int i = 0; i < 5; i++) tick(0, 1, 0, 1, "R4");
        for (int i = 0; i < 10; i++) tick(0, 0, 0, 1, "R5");

        // R7: select change away from the wrap is deferred
        tick(1, 0, 0, 0, "R6");
        for (int i = 0; i < 5; i++) tick(0, 0, 0, 0, "R7");
        for (int i = 0; i < 20; i++) tick(0, 0, 1, 1, "R7");

        // R8: misalign dut2, then common reset realigns
        tie2 = 0;
        en_n2 = 1'b1;
        tick(0, 0, 0, 1, "R8");
        tick(0, 0, 0, 1, "R8");
        en_n2 = 1'b0;
        tie2 = 1;
        tick(1, 0, 0, 1, "R6");
        for (int i = 0; i < 30; i++) tick(0, 0, 0, 1, "R8");

        // constrained random mix
        for (int i = 0; i < 800; i++) begin
            bit r, e, sa, sb;
            r  = ($urandom % 60) == 0;
            e  = ($urandom % 5) == 0;
            sa = (($urandom % 8) == 0) ? ~sel_a : sel_a;
            sb = (($urandom % 8) == 0) ? ~sel_b : sel_b;
            tick(r, e, sa, sb, r ? "R6" : (e ? "R4" : "R7"));
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule